// File: doc/BRIEF.md
# Constant-Coefficient Block Transpose FIR Filter

This block is a finite impulse response filter whose taps are fixed when the design is elaborated. It accepts a block of `L` new samples per clock and returns `L` filtered outputs per clock. Lane 0 of a block carries the newest sample x(4k), and lane `l` carries x(4k-l). The impulse response has `NT` taps, split into `M = NT/L` coefficient groups. With the default sizes (`L`=4, `NT`=16), the window that one block needs covers the seven samples x(4k) down to x(4k-6). Three of them are kept from the previous block.

There are no general multipliers. Each of the seven window samples drives its own constant-multiplier unit. That unit forms the sample times every tap it meets in the window, using canonic signed-digit shift-and-add terms. Taps of equal magnitude inside one unit share a single shift-add product, which is negated where the sign differs. Each product is reused by every window row that needs it.

The row sums form `M` partial result vectors. A transpose-form chain of one-block delays adds these vectors from the highest group down to group 0. The result is full precision, so nothing is rounded or saturated. The filter advances only on blocks flagged valid. Idle cycles leave its state untouched.

Top module: `firMcmBlock`

## Requirements
- R1: Output lane `l` (bits `[l*OW +: OW]`, where OW = B+CW+log2(NT)) carries y(4k-l) = sum over i of h(i)·x(4k-l-i), computed at full precision as a two's-complement value. Input lane `l` (bits `[l*B +: B]`) carries the signed sample x(4k-l).
- R2: `outValid` rises exactly two clock cycles after the clock edge that captures a block with `inValid` high. It stays high for exactly one cycle per input block.
- R3: Cycles with `inValid` low do not advance the filter, whatever is on `inSamples`. The output sequence depends only on the sequence of valid blocks.
- R4: While `outValid` is low, `outSamples` keeps its previous value.
- R5: A synchronous reset (`rst` high at a clock edge) clears `outValid` and `outSamples` to zero. It also clears all stored samples and partial sums, so the next output is computed as if every earlier sample were zero.
- R6: A single unit sample followed by zero blocks makes the outputs trace the coefficient sequence h(0)…h(NT-1), each at the lane and block position its delay implies.
- R7: Every output stays within ±(sum of |h(i)|)·2^(B-1). Inputs at full-scale extremes give the exact result without wraparound.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Marks `inSamples` as a block to be filtered |
| inSamples | input | L*B | L signed samples, lane 0 newest |
| outValid | output | 1 | Marks `outSamples` as a new output block |
| outSamples | output | L*OW | L signed full-precision outputs, lane 0 newest |

## Verification
The assertions check several properties on every cycle: the two-cycle relation between `inValid` and `outValid`, output stability while no result is flagged, the cleared state right after reset, and the full-scale magnitude bound on every lane. Only the bench scenarios can show that the values themselves are correct. The bench compares each lane against a direct convolution model over impulse, random, gapped and full-scale streams. It also checks that garbage presented during idle cycles and the history left before a mid-stream reset do not leak into later results.

// File: rtl/firMcmPkg.sv
package firMcmPkg;

  typedef struct packed {
    logic captureWin;
    logic shiftChain;
  } firStrobe_t;

  // Canonic signed-digit recoding: digit (-1, 0, +1) of constant c at weight 2^pos.
  function automatic int csdDigit(input int c, input int pos);
    int v;
    int d;
    v = c;
    d = 0;
    for (int b = 0; b <= pos; b++) begin
      if (v[0]) d = v[1] ? -1 : 1;
      else d = 0;
      v = (v - d) >>> 1;
    end
    return d;
  endfunction

endpackage

// File: rtl/firMcmUnit.sv
module firMcmUnit #(
  parameter int B = 12,
  parameter int CW = 9,
  parameter int NT = 16,
  parameter int L = 4,
  parameter int ILO = 0,
  parameter int IHI = 0,
  parameter int COEF [NT] = '{default: 0}
) (
  input  logic signed [B-1:0]     sample,
  output logic signed [B+CW-1:0]  prod [NT]
);
  import firMcmPkg::*;

  localparam int PW = B + CW;

  function automatic bit inUnit(input int t);
    return ((t % L) >= ILO) && ((t % L) <= IHI);
  endfunction

  // Earliest tap in this unit with the same magnitude, or -1 when none.
  function automatic int twinOf(input int t);
    for (int u = 0; u < t; u++) begin
      if (inUnit(u) && COEF[t] != 0 && (COEF[u] == COEF[t] || COEF[u] == -COEF[t]))
        return u;
    end
    return -1;
  endfunction

  logic signed [PW-1:0] ext;
  assign ext = PW'(sample);

  for (genvar t = 0; t < NT; t++) begin : g_tap
    localparam int TW = twinOf(t);
    if (!inUnit(t)) begin : g_idle
      assign prod[t] = '0;
    end else if (TW < 0) begin : g_own
      logic signed [PW-1:0] acc;
      always_comb begin
        acc = '0;
        for (int b = 0; b <= CW; b++) begin
          if (csdDigit(COEF[t], b) == 1) acc = acc + (ext <<< b);
          else if (csdDigit(COEF[t], b) == -1) acc = acc - (ext <<< b);
        end
      end
      assign prod[t] = acc;
    end else if (COEF[TW] == COEF[t]) begin : g_same
      assign prod[t] = prod[TW];
    end else begin : g_neg
      assign prod[t] = -prod[TW];
    end
  end

endmodule

// File: rtl/firControl.sv
module firControl
  import firMcmPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output firStrobe_t strobes,
  output logic       outValid
);
  logic stageValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageValid <= 1'b0;
      outValid   <= 1'b0;
    end else begin
      stageValid <= inValid;
      outValid   <= stageValid;
    end
  end

  always_comb begin
    strobes.captureWin = inValid;
    strobes.shiftChain = stageValid;
  end

endmodule

// File: rtl/firDatapath.sv
module firDatapath
  import firMcmPkg::*;
#(
  parameter int B = 12,
  parameter int CW = 9,
  parameter int NT = 16,
  parameter int L = 4,
  parameter int COEF [NT] = '{default: 0}
) (
  input  logic                                clk,
  input  logic                                rst,
  input  firStrobe_t                          strobes,
  input  logic [L*B-1:0]                      inSamples,
  output logic [L*(B+CW+$clog2(NT))-1:0]      outSamples
);
  localparam int M   = NT / L;
  localparam int WIN = 2 * L - 1;
  localparam int PW  = B + CW;
  localparam int OW  = PW + $clog2(NT);

  logic signed [B-1:0]  lane    [L];
  logic signed [B-1:0]  hist    [L-1];
  logic signed [B-1:0]  win     [WIN];
  logic signed [PW-1:0] prodAll [WIN][NT];
  logic signed [OW-1:0] rSum    [M][L];
  logic signed [OW-1:0] rReg    [M][L];
  logic signed [OW-1:0] chain   [M-1][L];
  logic signed [OW-1:0] chainNext [M][L];
  logic signed [OW-1:0] outReg  [L];

  for (genvar l = 0; l < L; l++) begin : g_lane
    assign lane[l] = inSamples[l*B +: B];
    assign outSamples[l*OW +: OW] = outReg[l];
  end

  for (genvar j = 0; j < WIN; j++) begin : g_win
    if (j < L) begin : g_cur
      assign win[j] = lane[j];
    end else begin : g_old
      assign win[j] = hist[j-L];
    end
    localparam int ILO = (j - L + 1 > 0) ? j - L + 1 : 0;
    localparam int IHI = (j < L - 1) ? j : L - 1;
    firMcmUnit #(
      .B(B), .CW(CW), .NT(NT), .L(L), .ILO(ILO), .IHI(IHI), .COEF(COEF)
    ) u_mcm (
      .sample(win[j]),
      .prod  (prodAll[j])
    );
  end

  // Row sums: row l of group m takes taps m*L+i from the unit of sample x(4k-l-i).
  always_comb begin
    for (int m = 0; m < M; m++) begin
      for (int l = 0; l < L; l++) begin
        rSum[m][l] = '0;
        for (int i = 0; i < L; i++)
          rSum[m][l] = rSum[m][l] + OW'(prodAll[l+i][m*L+i]);
      end
    end
  end

  // Transpose chain: group m adds the delayed sum of groups above it.
  for (genvar m = 0; m < M; m++) begin : g_chain
    for (genvar l = 0; l < L; l++) begin : g_cl
      if (m < M - 1) begin : g_mid
        assign chainNext[m][l] = rReg[m][l] + chain[m][l];
      end else begin : g_top
        assign chainNext[m][l] = rReg[m][l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < L - 1; t++) hist[t] <= '0;
      for (int m = 0; m < M; m++)
        for (int l = 0; l < L; l++) rReg[m][l] <= '0;
      for (int m = 0; m < M - 1; m++)
        for (int l = 0; l < L; l++) chain[m][l] <= '0;
      for (int l = 0; l < L; l++) outReg[l] <= '0;
    end else begin
      if (strobes.captureWin) begin
        for (int t = 0; t < L - 1; t++) hist[t] <= lane[t];
        for (int m = 0; m < M; m++)
          for (int l = 0; l < L; l++) rReg[m][l] <= rSum[m][l];
      end
      if (strobes.shiftChain) begin
        for (int m = 0; m < M - 1; m++)
          for (int l = 0; l < L; l++) chain[m][l] <= chainNext[m+1][l];
        for (int l = 0; l < L; l++) outReg[l] <= chainNext[0][l];
      end
    end
  end

endmodule

// File: rtl/firMcmBlock.sv
module firMcmBlock
  import firMcmPkg::*;
#(
  parameter int B = 12,
  parameter int CW = 9,
  parameter int NT = 16,
  parameter int L = 4,
  parameter int COEF [NT] = '{3, -7, 12, 25, -40, 61, -90, 127,
                              127, -90, 61, -40, 25, 12, -7, 3}
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            inValid,
  input  logic [L*B-1:0]                  inSamples,
  output logic                            outValid,
  output logic [L*(B+CW+$clog2(NT))-1:0]  outSamples
);
  firStrobe_t strobes;

  firControl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .outValid(outValid)
  );

  firDatapath #(
    .B(B), .CW(CW), .NT(NT), .L(L), .COEF(COEF)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .inSamples (inSamples),
    .outSamples(outSamples)
  );

endmodule

// File: rtl/firMcmBlockChecker.sv
module firMcmBlockChecker #(
  parameter int B = 12,
  parameter int CW = 9,
  parameter int NT = 16,
  parameter int L = 4,
  parameter int COEF [NT] = '{default: 0}
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            inValid,
  input logic                            outValid,
  input logic [L*(B+CW+$clog2(NT))-1:0]  outSamples
);
  localparam int OW = B + CW + $clog2(NT);

  function automatic longint absSum();
    longint s;
    s = 0;
    for (int t = 0; t < NT; t++) s += (COEF[t] < 0) ? -COEF[t] : COEF[t];
    return s;
  endfunction

  localparam longint BOUND = absSum() * (longint'(1) << (B - 1));

  logic [1:0] sinceRst;
  always_ff @(posedge clk) begin
    if (rst) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 2'd2) |-> (outValid == $past(inValid, 2)));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sinceRst != 2'd0 && !outValid) |-> $stable(outSamples));

  assert_reset_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd0) |-> (!outValid && outSamples == '0));

  for (genvar l = 0; l < L; l++) begin : g_bound
    logic signed [OW-1:0] laneVal;
    assign laneVal = outSamples[l*OW +: OW];
    assert_bound_R7: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (longint'(laneVal) <= BOUND && longint'(laneVal) >= -BOUND));
  end

endmodule

bind firMcmBlock firMcmBlockChecker #(
  .B(B), .CW(CW), .NT(NT), .L(L), .COEF(COEF)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inValid   (inValid),
  .outValid  (outValid),
  .outSamples(outSamples)
);

// File: tb/firMcmBlock_tb.sv
`timescale 1ns/1ps
module firMcmBlock_tb;
  localparam int B  = 12;
  localparam int CW = 9;
  localparam int NT = 16;
  localparam int L  = 4;
  localparam int OW = B + CW + $clog2(NT);
  localparam int H [NT] = '{3, -7, 12, 25, -40, 61, -90, 127,
                            127, -90, 61, -40, 25, 12, -7, 3};

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic [L*B-1:0]    inSamples = '0;
  logic              outValid;
  logic [L*OW-1:0]   outSamples;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  longint samp[$];
  longint expQ[$];
  string  tagQ[$];

  always #10 clk = ~clk;

  firMcmBlock #(.B(B), .CW(CW), .NT(NT), .L(L), .COEF(H)) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSamples(inSamples),
    .outValid(outValid), .outSamples(outSamples)
  );

  function automatic longint laneOut(input int l);
    logic signed [OW-1:0] v;
    v = outSamples[l*OW +: OW];
    return longint'(v);
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Driver: push a block (s[0] newest) and queue its expected outputs.
  task automatic sendBlock(input longint s[L], input string tag);
    int base;
    base = samp.size();
    for (int l = L - 1; l >= 0; l--) samp.push_back(s[l]);
    for (int l = 0; l < L; l++) begin
      longint acc;
      int pos;
      acc = 0;
      pos = base + (L - 1 - l);
      for (int i = 0; i < NT; i++)
        if (pos - i >= 0) acc += longint'(H[i]) * samp[pos - i];
      expQ.push_back(acc);
      tagQ.push_back(tag);
    end
    for (int l = 0; l < L; l++) inSamples[l*B +: B] = s[l][B-1:0];
    inValid = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      inValid = 1'b0;
      inSamples = {$urandom, $urandom};
      @(negedge clk);
    end
  endtask

  function automatic longint rnd();
    return longint'($urandom_range(0, 4095)) - 2048;
  endfunction

  // Monitor: pop expected lanes whenever a block is flagged.
  always @(negedge clk) begin
    if (!rst && outValid) begin
      for (int l = 0; l < L; l++) begin
        if (expQ.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R2: unexpected output lane %0d got %0d expected none", l, laneOut(l));
        end else begin
          check(tagQ.pop_front(), laneOut(l), expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint s[L];
    longint snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    check("R5 reset outValid", longint'(outValid), 0);
    check("R5 reset outSamples", longint'(outSamples == '0), 1);

    // R2: latency of a single block
    for (int l = 0; l < L; l++) s[l] = rnd();
    sendBlock(s, "R2 data");
    inValid = 1'b0;
    check("R2 not yet valid", longint'(outValid), 0);
    @(negedge clk);
    check("R2 valid after two edges", longint'(outValid), 1);
    idle(2);
    check("R2 single cycle valid", longint'(outValid), 0);

    // R6: impulse in lane 0, then in lane 3
    s = '{1, 0, 0, 0};
    sendBlock(s, "R6 impulse lane0");
    s = '{0, 0, 0, 0};
    for (int k = 0; k < 5; k++) sendBlock(s, "R6 tail");
    s = '{0, 0, 0, 1};
    sendBlock(s, "R6 impulse lane3");
    s = '{0, 0, 0, 0};
    for (int k = 0; k < 5; k++) sendBlock(s, "R6 tail");

    // R1: random back-to-back stream
    for (int k = 0; k < 30; k++) begin
      for (int l = 0; l < L; l++) s[l] = rnd();
      sendBlock(s, "R1 random");
    end

    // R3: gaps with garbage on the inputs
    for (int k = 0; k < 20; k++) begin
      for (int l = 0; l < L; l++) s[l] = rnd();
      sendBlock(s, "R3 gapped");
      idle($urandom_range(1, 3));
    end

    // R4: output held while no block is flagged
    for (int l = 0; l < L; l++) s[l] = rnd();
    sendBlock(s, "R4 data");
    idle(2);
    snap = laneOut(0);
    idle(1);
    check("R4 outValid low", longint'(outValid), 0);
    check("R4 held lane0", laneOut(0), snap);

    // R7: full-scale extremes
    s = '{-2048, -2048, -2048, -2048};
    for (int k = 0; k < 6; k++) sendBlock(s, "R7 min");
    s = '{2047, 2047, 2047, 2047};
    for (int k = 0; k < 6; k++) sendBlock(s, "R7 max");
    for (int k = 0; k < 6; k++) begin
      s = '{2047, -2048, 2047, -2048};
      sendBlock(s, "R7 alt");
    end

    // R5: mid-stream reset clears history
    idle(3);
    inValid = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    inValid = 1'b0;
    samp.delete();
    check("R5 post-reset outValid", longint'(outValid), 0);
    check("R5 post-reset outSamples", longint'(outSamples == '0), 1);
    for (int k = 0; k < 4; k++) begin
      for (int l = 0; l < L; l++) s[l] = rnd();
      sendBlock(s, "R5 after reset");
    end
    idle(4);
    check("R2 scoreboard drained", longint'(expQ.size()), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule